// File: doc/BRIEF.md
# Dual-Port Adapter Control Registers

This block is a compact 16-bit register file that sits between a host bus and a secondary-processor bus of an add-on adapter. It keeps an adapter-enable bit, a bus-ownership flag, a 3-bit ROM bank number and eight 16-bit mailbox words that the two sides use to pass messages. The host may write bytes or words and reads words. The secondary side writes and reads words, and it sees a fixed status word at offset 0.

The host has no effect on the block until it switches the adapter on. It does this with a byte write to offset 1, which raises a one-cycle start pulse. After that the host can move the ownership flag, pick a ROM bank and fill the mailbox. A change of bank raises a one-cycle pulse that carries the new number to the remapping logic outside the block. The secondary side can use the mailbox at any time. When both sides write the same mailbox word in the same cycle, the host write is kept.

Top module: `adapter_ctl_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the enable bit, the ownership flag, the bank number and all mailbox words are zero, and both pulses are low. A host word read returns the ownership flag in bit 15 and the enable bit in bit 0 at offset 0, and the bank in bits 2:0 at offset 4. Other host offsets outside the mailbox read zero.
- R2: While the enable bit is clear, every host write is dropped except a byte write to offset 1. The ownership flag, the bank and the mailbox keep their values, and no bank pulse is raised.
- R3: A host byte write to offset 1 while the enable bit is clear sets the bit and raises `start_pulse` for exactly one cycle. Later writes to offset 1 raise no pulse, and the bit stays set until reset.
- R4: When the adapter is enabled, a host byte write to offset 0 loads the ownership flag from data bit 7. A host word write to offset 0 loads it from data bit 15. No other bit of register 0 changes.
- R5: When the adapter is enabled, a host byte write to offset 5 takes data bits 2:0 as the bank. `bank_pulse` is high for one cycle, with `bank_sel` showing the new value, only when that value differs from the held bank. Byte writes to offset 4 have no effect.
- R6: A host word write to any offset other than 0 or the mailbox range acts as a byte write to that offset plus 1, using data bits 7:0. For example, a word write to offset 4 sets the bank.
- R7: When the adapter is enabled, a host word write to an offset whose bits 5:4 are 2'b10 (0x20 to 0x2F) stores all 16 bits in mailbox word (offset bits 3:1). A host read of that offset returns the word. Host byte writes to the mailbox are ignored.
- R8: A secondary word write to offsets 0x20 to 0x2F stores the word whatever the enable bit holds. A secondary word read of those offsets returns the mailbox word.
- R9: A secondary word read of offset 0 returns the ownership flag in bit 15 and a constant 1 in bit 9, with all other bits zero. Secondary reads of other offsets outside the mailbox return zero.
- R10: When the host and the secondary side write the same mailbox word in one cycle, the host data is stored. Writes to different words in the same cycle both take effect.
- R11: Each side keeps only the low 6 bits of its address as the offset. Host byte accesses use offset bit 0, and word accesses on either side treat it as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_word | input | 1 | 1: word write, 0: byte write (byte data in bits 7:0) |
| host_addr | input | HOST_AW (8) | Host write address |
| host_wdata | input | 16 | Host write data |
| host_rd_addr | input | HOST_AW (8) | Host word read address |
| host_rd_data | output | 16 | Host read data (combinational) |
| sec_wr_en | input | 1 | Secondary word write strobe |
| sec_addr | input | SEC_AW (8) | Secondary write address |
| sec_wdata | input | 16 | Secondary write data |
| sec_rd_addr | input | SEC_AW (8) | Secondary word read address |
| sec_rd_data | output | 16 | Secondary read data (combinational) |
| bank_pulse | output | 1 | One-cycle bank-change strobe |
| bank_sel | output | 3 | Held bank number |
| start_pulse | output | 1 | One-cycle strobe when the adapter is first enabled |

## Verification
A write presented before a rising edge changes the registers at that edge. The two pulses are registered at the same edge, so they are high for the whole cycle after it and low again after the next edge. Both read ports are combinational views of the registers, so a read made in the cycle after a write already returns the new value. The bench drives inputs on the falling edge. It samples one time unit after the rising edge that captures a write, and it samples reads one time unit after it applies the read address on a falling edge, so no check depends on the order of processes at an edge.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int OFS_W   = 6;
  localparam int DATA_W  = 16;
  localparam int BANK_W  = 3;
  localparam int MBOX_N  = 8;
  localparam int MBOX_IW = $clog2(MBOX_N);

  localparam int FM_BIT      = 15;
  localparam int PRESENT_BIT = 9;
  localparam int EN_BIT      = 0;

  localparam logic [OFS_W-1:0] OFS_CTRL      = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL_LOW  = 6'h01;
  localparam logic [OFS_W-1:0] OFS_BANK_WORD = 6'h04;
  localparam logic [OFS_W-1:0] OFS_BANK_LOW  = 6'h05;
  localparam logic [1:0]       MBOX_SEL      = 2'b10;

  typedef struct packed {
    logic              en_set;
    logic              fm_we;
    logic              fm_val;
    logic              bank_we;
    logic [BANK_W-1:0] bank_val;
  } ctrl_cmd_t;

  typedef struct packed {
    logic               we;
    logic [MBOX_IW-1:0] idx;
    logic [DATA_W-1:0]  val;
  } mbox_cmd_t;
endpackage

// File: rtl/adp_host_decode.sv
module adp_host_decode
  import adp_pkg::*;
#(
  parameter int HOST_AW = 8
) (
  input  logic                wr_en,
  input  logic                wr_word,
  input  logic [HOST_AW-1:0]  addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                en_q,
  output ctrl_cmd_t           ctrl_cmd,
  output mbox_cmd_t           mbox_cmd
);
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] byte_ofs;
  logic             byte_go;
  logic             unused_hi;

  assign unused_hi = ^addr[HOST_AW-1:OFS_W];

  always_comb begin
    ofs = addr[OFS_W-1:0];
    if (wr_word) ofs[0] = 1'b0;
  end

  // Route the access: word writes either hit register 0, the mailbox, or
  // fall through as a byte write to the odd neighbour.
  always_comb begin
    ctrl_cmd = '0;
    mbox_cmd = '0;
    byte_ofs = ofs;
    byte_go  = 1'b0;
    if (wr_en) begin
      if (!en_q) begin
        ctrl_cmd.en_set = !wr_word && (ofs == OFS_CTRL_LOW);
      end else if (wr_word) begin
        if (ofs == OFS_CTRL) begin
          ctrl_cmd.fm_we  = 1'b1;
          ctrl_cmd.fm_val = wdata[FM_BIT];
        end else if (ofs[OFS_W-1:OFS_W-2] == MBOX_SEL) begin
          mbox_cmd.we  = 1'b1;
          mbox_cmd.idx = ofs[MBOX_IW:1];
          mbox_cmd.val = wdata;
        end else begin
          byte_ofs = ofs | 6'h01;
          byte_go  = 1'b1;
        end
      end else begin
        byte_go = 1'b1;
      end

      if (byte_go) begin
        if (byte_ofs == OFS_CTRL) begin
          ctrl_cmd.fm_we  = 1'b1;
          ctrl_cmd.fm_val = wdata[7];
        end
        if (byte_ofs == OFS_BANK_LOW) begin
          ctrl_cmd.bank_we  = 1'b1;
          ctrl_cmd.bank_val = wdata[BANK_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/adp_ctrl_reg.sv
module adp_ctrl_reg
  import adp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_cmd_t         cmd,
  output logic              en_q,
  output logic              fm_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              bank_pulse_q,
  output logic              start_pulse_q
);
  logic              en_d, fm_d, bank_chg, start_d;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    en_d     = en_q | cmd.en_set;
    start_d  = cmd.en_set & ~en_q;
    fm_d     = cmd.fm_we ? cmd.fm_val : fm_q;
    bank_chg = cmd.bank_we && (cmd.bank_val != bank_q);
    bank_d   = bank_chg ? cmd.bank_val : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q          <= 1'b0;
      fm_q          <= 1'b0;
      bank_q        <= '0;
      bank_pulse_q  <= 1'b0;
      start_pulse_q <= 1'b0;
    end else begin
      if (cmd.en_set) en_q   <= en_d;
      if (cmd.fm_we)  fm_q   <= fm_d;
      if (bank_chg)   bank_q <= bank_d;
      bank_pulse_q  <= bank_chg;
      start_pulse_q <= start_d;
    end
  end
endmodule

// File: rtl/adp_mailbox.sv
module adp_mailbox
  import adp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  mbox_cmd_t                      host_cmd,
  input  mbox_cmd_t                      sec_cmd,
  output logic [MBOX_N-1:0][DATA_W-1:0]  mbox_q
);
  for (genvar i = 0; i < MBOX_N; i++) begin : g_word
    logic              host_hit, sec_hit, load;
    logic [DATA_W-1:0] word_d;

    always_comb begin
      host_hit = host_cmd.we && (host_cmd.idx == MBOX_IW'(i));
      sec_hit  = sec_cmd.we  && (sec_cmd.idx  == MBOX_IW'(i));
      load     = host_hit | sec_hit;
      word_d   = host_hit ? host_cmd.val : sec_cmd.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mbox_q[i] <= '0;
      else if (load) mbox_q[i] <= word_d;
    end
  end
endmodule

// File: rtl/adp_read_mux.sv
module adp_read_mux
  import adp_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int SEC_AW  = 8
) (
  input  logic [HOST_AW-1:0]              host_rd_addr,
  input  logic [SEC_AW-1:0]               sec_rd_addr,
  input  logic                            en_q,
  input  logic                            fm_q,
  input  logic [BANK_W-1:0]               bank_q,
  input  logic [MBOX_N-1:0][DATA_W-1:0]   mbox_q,
  output logic [DATA_W-1:0]               host_rd_data,
  output logic [DATA_W-1:0]               sec_rd_data
);
  logic [OFS_W-1:0] h_ofs, s_ofs;
  logic             unused_bits;

  assign unused_bits = ^{host_rd_addr[HOST_AW-1:OFS_W], host_rd_addr[0],
                         sec_rd_addr[SEC_AW-1:OFS_W], sec_rd_addr[0]};

  always_comb begin
    h_ofs = {host_rd_addr[OFS_W-1:1], 1'b0};
    host_rd_data = '0;
    if (h_ofs == OFS_CTRL) begin
      host_rd_data[FM_BIT] = fm_q;
      host_rd_data[EN_BIT] = en_q;
    end else if (h_ofs == OFS_BANK_WORD) begin
      host_rd_data[BANK_W-1:0] = bank_q;
    end else if (h_ofs[OFS_W-1:OFS_W-2] == MBOX_SEL) begin
      host_rd_data = mbox_q[h_ofs[MBOX_IW:1]];
    end
  end

  always_comb begin
    s_ofs = {sec_rd_addr[OFS_W-1:1], 1'b0};
    sec_rd_data = '0;
    if (s_ofs == OFS_CTRL) begin
      sec_rd_data[FM_BIT]      = fm_q;
      sec_rd_data[PRESENT_BIT] = 1'b1;
    end else if (s_ofs[OFS_W-1:OFS_W-2] == MBOX_SEL) begin
      sec_rd_data = mbox_q[s_ofs[MBOX_IW:1]];
    end
  end
endmodule

// File: rtl/adapter_ctl_regs.sv
module adapter_ctl_regs
  import adp_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int SEC_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_wr_word,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  input  logic [HOST_AW-1:0] host_rd_addr,
  output logic [15:0]        host_rd_data,
  input  logic               sec_wr_en,
  input  logic [SEC_AW-1:0]  sec_addr,
  input  logic [15:0]        sec_wdata,
  input  logic [SEC_AW-1:0]  sec_rd_addr,
  output logic [15:0]        sec_rd_data,
  output logic               bank_pulse,
  output logic [2:0]         bank_sel,
  output logic               start_pulse
);
  ctrl_cmd_t                     host_ctrl;
  mbox_cmd_t                     host_mbox, sec_mbox;
  logic                          en_q, fm_q;
  logic [BANK_W-1:0]             bank_q;
  logic [MBOX_N-1:0][DATA_W-1:0] mbox_q;
  logic [OFS_W-1:0]              sec_ofs;
  logic                          unused_sec;

  assign unused_sec = ^{sec_addr[SEC_AW-1:OFS_W], sec_addr[0]};

  adp_host_decode #(.HOST_AW(HOST_AW)) u_dec (
    .wr_en    (host_wr_en),
    .wr_word  (host_wr_word),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .en_q     (en_q),
    .ctrl_cmd (host_ctrl),
    .mbox_cmd (host_mbox)
  );

  // Secondary side: word writes only, mailbox range only, never gated.
  always_comb begin
    sec_ofs      = {sec_addr[OFS_W-1:1], 1'b0};
    sec_mbox.we  = sec_wr_en && (sec_ofs[OFS_W-1:OFS_W-2] == MBOX_SEL);
    sec_mbox.idx = sec_ofs[MBOX_IW:1];
    sec_mbox.val = sec_wdata;
  end

  adp_ctrl_reg u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (host_ctrl),
    .en_q          (en_q),
    .fm_q          (fm_q),
    .bank_q        (bank_q),
    .bank_pulse_q  (bank_pulse),
    .start_pulse_q (start_pulse)
  );

  adp_mailbox u_mbox (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_cmd (host_mbox),
    .sec_cmd  (sec_mbox),
    .mbox_q   (mbox_q)
  );

  adp_read_mux #(.HOST_AW(HOST_AW), .SEC_AW(SEC_AW)) u_rd (
    .host_rd_addr (host_rd_addr),
    .sec_rd_addr  (sec_rd_addr),
    .en_q         (en_q),
    .fm_q         (fm_q),
    .bank_q       (bank_q),
    .mbox_q       (mbox_q),
    .host_rd_data (host_rd_data),
    .sec_rd_data  (sec_rd_data)
  );

  assign bank_sel = bank_q;
endmodule

// File: rtl/adp_ctl_checker.sv
module adp_ctl_checker #(
  parameter int HOST_AW = 8,
  parameter int SEC_AW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_q,
  input logic               fm_q,
  input logic [2:0]         bank_sel,
  input logic               bank_pulse,
  input logic               start_pulse,
  input logic               host_wr_en,
  input logic               host_wr_word,
  input logic [HOST_AW-1:0] host_addr,
  input logic [15:0]        host_wdata,
  input logic [SEC_AW-1:0]  sec_rd_addr,
  input logic [15:0]        sec_rd_data
);
  AST_DISABLED_FM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(fm_q));                                        // R2
  AST_DISABLED_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !bank_pulse);                                          // R2
  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (en_q && !$past(en_q)));                         // R3
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);                                                  // R3
  AST_FM_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && en_q && !host_wr_word && host_addr[5:0] == 6'h00)
      |=> (fm_q == $past(host_wdata[7])));                           // R4
  AST_BANK_CHANGE_PULSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> bank_pulse);                   // R5
  AST_BANK_PULSE_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    bank_pulse |-> (bank_sel != $past(bank_sel)));                   // R5
  AST_SEC_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rd_addr[5:1] == 5'd0) |-> (sec_rd_data == ({fm_q, 15'd0} | 16'h0200))); // R9
endmodule

bind adapter_ctl_regs adp_ctl_checker #(.HOST_AW(HOST_AW), .SEC_AW(SEC_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_q         (en_q),
  .fm_q         (fm_q),
  .bank_sel     (bank_sel),
  .bank_pulse   (bank_pulse),
  .start_pulse  (start_pulse),
  .host_wr_en   (host_wr_en),
  .host_wr_word (host_wr_word),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .sec_rd_addr  (sec_rd_addr),
  .sec_rd_data  (sec_rd_data)
);

// File: tb/tb_adapter_ctl_regs.sv
`timescale 1ns/1ps
module tb_adapter_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_wr_word;
  logic [7:0]  host_addr, host_rd_addr;
  logic [15:0] host_wdata, host_rd_data;
  logic        sec_wr_en;
  logic [7:0]  sec_addr, sec_rd_addr;
  logic [15:0] sec_wdata, sec_rd_data;
  logic        bank_pulse, start_pulse;
  logic [2:0]  bank_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adapter_ctl_regs dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_word(host_wr_word), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .sec_wr_en(sec_wr_en), .sec_addr(sec_addr), .sec_wdata(sec_wdata),
    .sec_rd_addr(sec_rd_addr), .sec_rd_data(sec_rd_data),
    .bank_pulse(bank_pulse), .bank_sel(bank_sel), .start_pulse(start_pulse)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One write cycle; pulses are sampled just after the capturing edge.
  task automatic host_wr(input bit word, input logic [7:0] a, input logic [15:0] d,
                         output logic bp, output logic [2:0] bn, output logic sp);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_word = word; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    bp = bank_pulse; bn = bank_sel; sp = start_pulse;
    host_wr_en = 1'b0;
  endtask

  task automatic sec_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    sec_wr_en = 1'b1; sec_addr = a; sec_wdata = d;
    @(posedge clk); #1;
    sec_wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); host_rd_addr = a; #1; d = host_rd_data;
  endtask

  task automatic sec_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); sec_rd_addr = a; #1; d = sec_rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 bank_pulse after reset", {15'd0, bank_pulse}, 16'd0);
    chk("R1 start_pulse after reset", {15'd0, start_pulse}, 16'd0);
    host_rd(8'h00, d); chk("R1 host reg0", d, 16'h0000);
    host_rd(8'h04, d); chk("R1 host bank", d, 16'h0000);
    host_rd(8'h2A, d); chk("R1 host mailbox", d, 16'h0000);
    host_rd(8'h10, d); chk("R1 host unmapped", d, 16'h0000);
    sec_rd(8'h00, d);  chk("R9 sec status after reset", d, 16'h0200);
  endtask

  task automatic t_disabled();
    logic bp, sp; logic [2:0] bn; logic [15:0] d;
    host_wr(1'b1, 8'h20, 16'hBEEF, bp, bn, sp);
    host_wr(1'b0, 8'h05, 16'h0003, bp, bn, sp);
    chk("R2 no bank pulse while disabled", {15'd0, bp}, 16'd0);
    host_wr(1'b1, 8'h00, 16'h8000, bp, bn, sp);
    host_wr(1'b1, 8'h04, 16'h0002, bp, bn, sp);
    chk("R2 no start on word write", {15'd0, sp}, 16'd0);
    host_rd(8'h20, d); chk("R2 mailbox unchanged", d, 16'h0000);
    host_rd(8'h04, d); chk("R2 bank unchanged", d, 16'h0000);
    host_rd(8'h00, d); chk("R2 reg0 unchanged", d, 16'h0000);
    sec_wr(8'h22, 16'h1234);
    sec_rd(8'h22, d);  chk("R8 sec mailbox while disabled", d, 16'h1234);
    host_rd(8'h22, d); chk("R8 host sees sec mailbox", d, 16'h1234);
  endtask

  task automatic t_enable();
    logic bp, sp; logic [2:0] bn; logic [15:0] d;
    host_wr(1'b0, 8'h01, 16'h0000, bp, bn, sp);
    chk("R3 start pulse", {15'd0, sp}, 16'd1);
    @(posedge clk); #1;
    chk("R3 start pulse one cycle", {15'd0, start_pulse}, 16'd0);
    host_rd(8'h00, d); chk("R3 enable bit", d, 16'h0001);
    host_wr(1'b0, 8'h01, 16'h00FF, bp, bn, sp);
    chk("R3 no second start", {15'd0, sp}, 16'd0);
    host_rd(8'h00, d); chk("R3 enable kept", d, 16'h0001);
  endtask

  task automatic t_fm();
    logic bp, sp; logic [2:0] bn; logic [15:0] d;
    host_wr(1'b0, 8'h00, 16'h0080, bp, bn, sp);
    host_rd(8'h00, d); chk("R4 byte sets FM", d, 16'h8001);
    sec_rd(8'h01, d);  chk("R9 sec status with FM", d, 16'h8200);
    host_wr(1'b0, 8'h00, 16'hFF7F, bp, bn, sp);
    host_rd(8'h00, d); chk("R4 byte clears FM only", d, 16'h0001);
    host_wr(1'b1, 8'h00, 16'hFFFF, bp, bn, sp);
    host_rd(8'h00, d); chk("R4 word sets FM", d, 16'h8001);
    host_wr(1'b1, 8'h00, 16'h7FFE, bp, bn, sp);
    host_rd(8'h00, d); chk("R4 word clears FM, keeps enable", d, 16'h0001);
  endtask

  task automatic t_bank();
    logic bp, sp; logic [2:0] bn; logic [15:0] d;
    host_wr(1'b0, 8'h05, 16'h00FD, bp, bn, sp);
    chk("R5 bank pulse", {15'd0, bp}, 16'd1);
    chk("R5 bank value", {13'd0, bn}, 16'd5);
    @(posedge clk); #1;
    chk("R5 bank pulse one cycle", {15'd0, bank_pulse}, 16'd0);
    host_wr(1'b0, 8'h05, 16'h0005, bp, bn, sp);
    chk("R5 same bank no pulse", {15'd0, bp}, 16'd0);
    host_wr(1'b0, 8'h04, 16'h0007, bp, bn, sp);
    chk("R5 byte offset 4 no pulse", {15'd0, bp}, 16'd0);
    host_rd(8'h04, d); chk("R5 bank held", d, 16'h0005);
    host_wr(1'b1, 8'h04, 16'h1206, bp, bn, sp);
    chk("R6 word to 4 pulses", {15'd0, bp}, 16'd1);
    chk("R6 word to 4 bank", {13'd0, bn}, 16'd6);
    host_wr(1'b1, 8'h06, 16'h0003, bp, bn, sp);
    host_rd(8'h04, d); chk("R6 word to 6 ignored", d, 16'h0006);
  endtask

  task automatic t_mbox();
    logic bp, sp; logic [2:0] bn; logic [15:0] d;
    for (int i = 0; i < 8; i++)
      host_wr(1'b1, 8'h20 + 8'(2*i), 16'hA000 + 16'(i), bp, bn, sp);
    for (int i = 0; i < 8; i++) begin
      host_rd(8'h20 + 8'(2*i), d);
      chk("R7 mailbox word", d, 16'hA000 + 16'(i));
    end
    host_wr(1'b0, 8'h21, 16'h0055, bp, bn, sp);
    host_rd(8'h20, d); chk("R7 byte write to mailbox ignored", d, 16'hA000);
    host_wr(1'b1, 8'hE5, 16'h1111, bp, bn, sp);
    host_rd(8'h24, d); chk("R11 upper bits and bit0 dropped", d, 16'h1111);
    host_rd(8'hA5, d); chk("R11 read alias", d, 16'h1111);
    sec_wr(8'h6F, 16'h4242);
    host_rd(8'h2E, d); chk("R8 sec write seen by host", d, 16'h4242);
    sec_rd(8'h10, d);  chk("R9 sec unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_word = 1'b1; host_addr = 8'h26; host_wdata = 16'hAAAA;
    sec_wr_en = 1'b1; sec_addr = 8'h26; sec_wdata = 16'h5555;
    @(posedge clk); #1;
    host_wr_en = 1'b0; sec_wr_en = 1'b0;
    sec_rd(8'h26, d); chk("R10 host wins", d, 16'hAAAA);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = 8'h28; host_wdata = 16'h0F0F;
    sec_wr_en = 1'b1; sec_addr = 8'h2A; sec_wdata = 16'hF0F0;
    @(posedge clk); #1;
    host_wr_en = 1'b0; sec_wr_en = 1'b0;
    host_rd(8'h28, d); chk("R10 host word lands", d, 16'h0F0F);
    host_rd(8'h2A, d); chk("R10 sec word lands", d, 16'hF0F0);
  endtask

  initial begin
    rst_n = 1'b0;
    host_wr_en = 1'b0; host_wr_word = 1'b0; host_addr = '0; host_wdata = '0;
    host_rd_addr = '0; sec_wr_en = 1'b0; sec_addr = '0; sec_wdata = '0; sec_rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_enable();
    t_fm();
    t_bank();
    t_mbox();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule